// File: doc/BRIEF.md
# Accumulating Register-File ALU Datapath

This block is a narrow arithmetic datapath built around a small register file. A write-side selector picks the word to be written: either an external data value or the current ALU result. The register file has one write port and one read port. The read port does two jobs. It feeds a holding register, which keeps an earlier read as the ALU's first operand (A). It also feeds the ALU's second operand (B) directly.

Because the ALU result can be written back into any word, a controller or test sequencer can chain operations. It latches one word, reads another, computes, and stores the result. The words that are not targeted keep their values. Every control comes straight from input pins, and there is no internal sequencing. The ALU result and its carry are visible combinationally, so a write-back in the same cycle stores exactly what is shown.

Top module: `regalu_datapath`

## Requirements
- R1: A synchronous active-high reset clears all register-file words and the holding register to zero.
- R2: On a rising clock edge with `wr_en` high, the word at `wr_addr` takes the write data and every other word is unchanged. With `wr_en` low, no word changes.
- R3: The write data is `din` when `in_sel` is 0 and the ALU result `alu_res` when `in_sel` is 1.
- R4: `rd_data` shows the word at `rd_addr` combinationally and is operand B.
- R5: On a rising clock edge with `hold_en` high, the holding register captures `rd_data`. With `hold_en` low, it keeps its value. Its content is operand A.
- R6: With `mode`=0 and `fsel`=00, `alu_res` is (A+B) mod 16 and `alu_cout` is the carry out of bit 3.
- R7: With `mode`=0 and `fsel`=01, `alu_res` is (A-B-1) mod 16, computed as A plus the inverse of B. `alu_cout` is the carry of that sum, which is 1 exactly when A > B.
- R8: With `mode`=1, `fsel`=00 gives A OR B and `fsel`=01 gives A AND NOT B. `alu_cout` is 0 in both cases.
- R9: With `fsel`=10 or 11, in either mode, `alu_res` equals A and `alu_cout` is 0.
- R10: After words 0..3 are loaded with 2, 3, 4 and 5, three latch-add-write-back steps into word 0 leave 0xE in word 0 and 3, 4, 5 in words 1..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 4 | External write data |
| in_sel | input | 1 | Write-data select: 0 external, 1 ALU result |
| wr_en | input | 1 | Register-file write enable |
| wr_addr | input | 2 | Register-file write address |
| rd_addr | input | 2 | Register-file read address |
| hold_en | input | 1 | Holding-register capture enable |
| mode | input | 1 | 0 arithmetic, 1 logic |
| fsel | input | 2 | Function select within the mode |
| rd_data | output | 4 | Read-port word (operand B) |
| alu_res | output | 4 | ALU result |
| alu_cout | output | 1 | ALU carry out |

## Verification
The bench aims at the following corner cases:
- **Subtract-minus-one.** It checks A greater than, equal to and less than B. A design that used a true subtract, or inverted the carry sense, would return the wrong value or carry when A equals B.
- **Addition wrap-around.** A design that lost the carry or failed to wrap would show it on an overflowing add.
- **Holding register.** It is checked both with capture disabled and with the read address moved. A register loaded every cycle would track B instead of keeping A.
- **Write-back chain.** It checks that results land only in the addressed word. A decode error, or a write that happens when disabled, would corrupt the untouched operands.

// File: rtl/regalu_pkg.sv
package regalu_pkg;

  // ALU operating mode
  typedef enum logic {
    MODE_ARITH = 1'b0,
    MODE_LOGIC = 1'b1
  } alu_mode_e;

  // Function select inside a mode
  typedef enum logic [1:0] {
    FN_PRIMARY   = 2'b00,  // add / or
    FN_SECONDARY = 2'b01,  // a + ~b / and-not
    FN_PASS_LO   = 2'b10,  // pass operand A
    FN_PASS_HI   = 2'b11   // pass operand A
  } alu_fn_e;

endpackage

// File: rtl/regalu_regfile.sv
module regalu_regfile #(
  parameter int W     = 4,
  parameter int WORDS = 4,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] word_q [WORDS];

  // One register per word; each decodes its own write strobe
  for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
    logic sel_w;
    assign sel_w = wr_en && (wr_addr == AW'(gi));

    always_ff @(posedge clk) begin
      if (rst) begin
        word_q[gi] <= '0;
      end else if (sel_w) begin
        word_q[gi] <= wr_data;
      end
    end
  end

  // Asynchronous read port
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (rd_addr == AW'(i)) rd_data = word_q[i];
    end
  end

endmodule

// File: rtl/regalu_hold.sv
module regalu_hold #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (cap_en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/regalu_alu.sv
module regalu_alu
  import regalu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         mode,
  input  logic [1:0]   fsel,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res,
  output logic         cout
);

  logic [W:0]   sum_add;
  logic [W:0]   sum_inv;
  logic [W-1:0] lg_or;
  logic [W-1:0] lg_andn;
  alu_fn_e      fn;
  alu_mode_e    md;

  assign fn      = alu_fn_e'(fsel);
  assign md      = alu_mode_e'(mode);
  assign sum_add = {1'b0, opa} + {1'b0, opb};
  assign sum_inv = {1'b0, opa} + {1'b0, ~opb};
  assign lg_or   = opa | opb;
  assign lg_andn = opa & ~opb;

  always_comb begin
    res  = opa;
    cout = 1'b0;
    unique case (fn)
      FN_PRIMARY: begin
        if (md == MODE_ARITH) begin
          res  = sum_add[W-1:0];
          cout = sum_add[W];
        end else begin
          res  = lg_or;
        end
      end
      FN_SECONDARY: begin
        if (md == MODE_ARITH) begin
          res  = sum_inv[W-1:0];
          cout = sum_inv[W];
        end else begin
          res  = lg_andn;
        end
      end
      FN_PASS_LO, FN_PASS_HI: begin
        res  = opa;
        cout = 1'b0;
      end
      default: begin
        res  = opa;
        cout = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/regalu_datapath.sv
module regalu_datapath #(
  parameter int W     = 4,
  parameter int WORDS = 4,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  din,
  input  logic          in_sel,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] rd_addr,
  input  logic          hold_en,
  input  logic          mode,
  input  logic [1:0]    fsel,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  alu_res,
  output logic          alu_cout
);

  logic [W-1:0] wdata;
  logic [W-1:0] opa_q;

  // Write-side selector: external data or ALU feedback
  assign wdata = in_sel ? alu_res : din;

  regalu_regfile #(.W(W), .WORDS(WORDS)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wdata),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  regalu_hold #(.W(W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .cap_en (hold_en),
    .d      (rd_data),
    .q      (opa_q)
  );

  regalu_alu #(.W(W)) u_alu (
    .mode (mode),
    .fsel (fsel),
    .opa  (opa_q),
    .opb  (rd_data),
    .res  (alu_res),
    .cout (alu_cout)
  );

endmodule

// File: rtl/regalu_checker.sv
module regalu_checker #(
  parameter int W  = 4,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [W-1:0]  din,
  input logic          in_sel,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] rd_addr,
  input logic          hold_en,
  input logic          mode,
  input logic [1:0]    fsel,
  input logic [W-1:0]  rd_data,
  input logic [W-1:0]  alu_res,
  input logic          alu_cout
);

  // R1: first cycle after reset reads zero everywhere
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == '0));

  // R2/R3: written word reads back the selected write data
  p_write_back_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !$past(rst)) |=>
      ((rd_addr != $past(wr_addr)) || (rd_data == $past(in_sel ? alu_res : din))));

  // R5: capture of the read word into operand A
  p_hold_capture_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hold_en) && fsel[1]) |-> (alu_res == $past(rd_data)));

  // R5: operand A is held while capture is off
  p_hold_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(hold_en) && fsel[1] && $past(fsel[1]))
      |-> (alu_res == $past(alu_res)));

  // R8: logic functions never raise carry
  p_logic_nocarry_r8: assert property (@(posedge clk) disable iff (rst)
    (mode && !fsel[1]) |-> !alu_cout);

  // R9: pass-through never raises carry
  p_pass_nocarry_r9: assert property (@(posedge clk) disable iff (rst)
    fsel[1] |-> !alu_cout);

endmodule

bind regalu_datapath regalu_checker #(.W(W), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .din      (din),
  .in_sel   (in_sel),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .rd_addr  (rd_addr),
  .hold_en  (hold_en),
  .mode     (mode),
  .fsel     (fsel),
  .rd_data  (rd_data),
  .alu_res  (alu_res),
  .alu_cout (alu_cout)
);

// File: tb/regalu_datapath_tb.sv
`timescale 1ns/1ps
module regalu_datapath_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] din;
  logic       in_sel;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [1:0] rd_addr;
  logic       hold_en;
  logic       mode;
  logic [1:0] fsel;
  logic [3:0] rd_data;
  logic [3:0] alu_res;
  logic       alu_cout;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  regalu_datapath u_dut (
    .clk(clk), .rst(rst), .din(din), .in_sel(in_sel), .wr_en(wr_en),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .hold_en(hold_en), .mode(mode),
    .fsel(fsel), .rd_data(rd_data), .alu_res(alu_res), .alu_cout(alu_cout)
  );

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; hold_en = 0; in_sel = 0;
  endtask

  task automatic put(input logic [1:0] a, input logic [3:0] v);
    wr_en = 1; in_sel = 0; wr_addr = a; din = v;
    step();
    wr_en = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [3:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  // latch word a as A, present word b as B
  task automatic load_ab(input logic [1:0] a, input logic [1:0] b);
    rd_addr = a; hold_en = 1;
    step();
    hold_en = 0; rd_addr = b; #1;
  endtask

  task automatic t_reset();
    logic [3:0] v;
    rst = 1; idle(); din = 4'hF; wr_addr = 0; rd_addr = 0; mode = 0; fsel = 2'b10;
    step(); step();
    rst = 0; #1;
    for (int i = 0; i < 4; i++) begin
      peek(i[1:0], v);
      check("R1 word zero", {1'b0, v}, 5'h0);
    end
    check("R1 latch zero", {alu_cout, alu_res}, 5'h0);
  endtask

  task automatic t_write_read();
    logic [3:0] v;
    put(0, 4'h3); put(1, 4'h4); put(2, 4'hA); put(3, 4'h5);
    peek(0, v); check("R2 word0", {1'b0, v}, 5'h3);
    peek(2, v); check("R4 word2", {1'b0, v}, 5'hA);
    // write disabled: no change
    wr_en = 0; wr_addr = 1; din = 4'hC; step();
    peek(1, v); check("R2 no write", {1'b0, v}, 5'h4);
  endtask

  task automatic t_hold();
    fsel = 2'b10; mode = 0;
    load_ab(2, 3);
    check("R5 capture", {alu_cout, alu_res}, 5'h0A);
    rd_addr = 0; step();
    check("R5 keep", {alu_cout, alu_res}, 5'h0A);
    hold_en = 1; step(); hold_en = 0; #1;
    check("R5 recapture", {alu_cout, alu_res}, 5'h03);
  endtask

  task automatic t_arith();
    mode = 0; fsel = 2'b00;
    load_ab(0, 1); check("R6 3+4", {alu_cout, alu_res}, 5'h07);
    put(0, 4'hC); put(1, 4'h6);
    load_ab(0, 1); check("R6 C+6 wrap", {alu_cout, alu_res}, 5'h12);
    fsel = 2'b01;
    load_ab(2, 3); check("R7 A-5-1", {alu_cout, alu_res}, 5'h14);
    load_ab(3, 3); check("R7 equal", {alu_cout, alu_res}, 5'h0F);
    put(0, 4'h3); put(1, 4'h4);
    load_ab(0, 1); check("R7 less", {alu_cout, alu_res}, 5'h0E);
  endtask

  task automatic t_logic();
    mode = 1; fsel = 2'b00;
    load_ab(2, 3); check("R8 or", {alu_cout, alu_res}, 5'h0F);
    fsel = 2'b01;
    load_ab(0, 1); check("R8 andnot", {alu_cout, alu_res}, 5'h03);
    put(0, 4'hF);
    load_ab(0, 3); check("R8 andnot2", {alu_cout, alu_res}, 5'h0A);
  endtask

  task automatic t_pass();
    mode = 0; fsel = 2'b10;
    load_ab(2, 1); check("R9 pass arith", {alu_cout, alu_res}, 5'h0A);
    mode = 1; fsel = 2'b11; #1;
    check("R9 pass logic", {alu_cout, alu_res}, 5'h0A);
  endtask

  task automatic t_chain();
    logic [3:0] v;
    put(0, 4'h2); put(1, 4'h3); put(2, 4'h4); put(3, 4'h5);
    mode = 0; fsel = 2'b00;
    for (int k = 1; k < 4; k++) begin
      load_ab(0, k[1:0]);
      in_sel = 1; wr_en = 1; wr_addr = 0;
      step();
      idle();
    end
    peek(0, v); check("R10 sum", {1'b0, v}, 5'h0E);
    peek(1, v); check("R10 keep1", {1'b0, v}, 5'h3);
    peek(2, v); check("R10 keep2", {1'b0, v}, 5'h4);
    peek(3, v); check("R10 keep3", {1'b0, v}, 5'h5);
    // R3: feedback vs external
    load_ab(1, 2);
    in_sel = 1; wr_en = 1; wr_addr = 3; din = 4'h0; step(); idle();
    peek(3, v); check("R3 alu path", {1'b0, v}, 5'h7);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_write_read();
    t_hold();
    t_arith();
    t_logic();
    t_pass();
    t_chain();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule